// File: doc/BRIEF.md
# Extended Match Channel Timer

This block holds eight match channels, numbered 4 to 11. Each channel has a match register, a counter and a control register. A channel compares its match value against a counter. That counter is either a shared group counter or, when the control register says so, the channel's own counter. Every counter advances on one of eight tick inputs, chosen by its control register. The tick inputs stand in for the selectable count clocks.

When a channel's match occurs and the channel's enable bit is set, a status bit is recorded. A single interrupt line stays high while any status bit is pending. Software clears status bits by writing ones to them. Channels can run in one-shot or periodic mode, and can return their counter to zero on a match. Channels 9 and 11 can also capture the counter of the channel below them into a snapshot register when their own counter is read.

Access goes through a plain word-addressed register port. A write takes effect at the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one cycle after `bus_rd` and is zero in any other cycle. The port has no back-pressure: every access completes in a single cycle.

Top module: `ext_match_timer`

## Requirements
- R1: Control bits 2:0 pick tick input `tick_src[sel]` for the counter. A source whose bit in parameter `SRC_AVAIL` (default 8'h3F, so sources 6 and 7 are missing) is clear never advances the counter. A counter with no tick on its selected source holds its value.
- R2: The word address is formed as {region[1:0], index[2:0]}, where index 0 to 7 means channel 4 to 11. Region 0 holds the match registers, region 1 the counters and region 2 the control registers. In region 3, index 0 is status, index 1 is enable and index 2 is the snapshot. With control bit 7 clear, channels 4 to 7 compare against channel 4's counter, channels 8 and 9 against channel 8's counter, and channels 10 and 11 against channel 10's counter. With bit 7 set, a channel uses and advances its own counter. The counter of a channel that is not the head of its group and has bit 7 clear never advances.
- R3: The control registers of channels 4 to 7 keep only bits 7:0. Those of channels 8 to 11 keep bits 9:0. All other bits read as zero.
- R4: On channels 8 to 11, control bit 8 forces tick source 0, whatever bits 2:0 hold.
- R5: A match occurs on the tick that advances the compared counter to the channel's match value. The match sets the status bit for channel n, which is bit n of the status word, but only if enable bit n of the enable word is set.
- R6: With control bit 3 set, a match loads zero into the compared counter instead of the match value.
- R7: With control bit 6 clear, a channel matches once and then stays silent. Any write to that channel's match or control register re-arms it. With bit 6 set, the channel matches on every equality.
- R8: On channels 9 and 11, with control bit 9 set, reading the channel's counter captures the counter of channel 8 or 10, respectively, into the snapshot register. The snapshot holds its value until the next capture.
- R9: `irq` is high while any status bit is pending. Writing ones to status bits clears them, and `irq` falls only after such a write leaves no bit pending.
- R10: Writing a counter loads the written value at that edge. The load takes priority over a tick in the same cycle.
- R11: After reset, all registers read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_src | input | 8 | Count-enable pulses, one per clock source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address {region, index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq | output | 1 | Combined match interrupt |

## Verification
The hardest states to reach from the ports are the one-shot silent state and the re-arm that follows it. The only sign of either is a match that does not happen. The stimulus first lets a one-shot channel match and clears its status. It then rewinds the counter through the register port and replays the same ticks to show that no status appears. Finally it rewrites the control register and replays the ticks once more to show the match returning. For the snapshot, the lower counter is parked on a missing tick source, so its captured value is exact no matter when the read lands.

// File: rtl/xmt_pkg.sv
package xmt_pkg;
  localparam int NCH    = 8;
  localparam int NSRC   = 8;
  localparam int B_RST  = 3;
  localparam int B_PER  = 6;
  localparam int B_OWN  = 7;
  localparam int B_F0   = 8;
  localparam int B_SNAP = 9;

  typedef enum logic [1:0] {RG_MATCH = 2'd0, RG_COUNT = 2'd1, RG_CTRL = 2'd2, RG_MISC = 2'd3} region_e;

  function automatic int head_of(input int i);
    if (i < 4) return 0;
    else if (i < 6) return 4;
    else return 6;
  endfunction
endpackage

// File: rtl/xmt_counter.sv
module xmt_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] nxt,
  output logic          adv
);
  assign nxt = cnt + 1'b1;
  assign adv = tick && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (load) cnt <= load_val;
    else if (adv)  cnt <= clr ? '0 : nxt;
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> cnt == $past(cnt));
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && clr) |=> cnt == '0);
endmodule

// File: rtl/xmt_match.sv
module xmt_match #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] nxt,
  input  logic [CW-1:0] cmp,
  input  logic          periodic,
  input  logic          rearm,
  output logic          hit
);
  logic done_q;

  assign hit = adv && (nxt == cmp) && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  done_q <= 1'b0;
    else if (rearm)              done_q <= 1'b0;
    else if (hit && !periodic)   done_q <= 1'b1;
  end

  assert_oneshot_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(adv && !periodic && nxt == cmp));
endmodule

// File: rtl/ext_match_timer.sv
module ext_match_timer
  import xmt_pkg::*;
#(
  parameter int          CW        = 32,
  parameter logic [7:0]  SRC_AVAIL = 8'h3F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  tick_src,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int ST_LO = 4;

  region_e     rg;
  logic [2:0]  ix;
  assign rg = region_e'(bus_addr[4:3]);
  assign ix = bus_addr[2:0];

  logic wr_match, wr_count, wr_ctrl, wr_status, wr_enable, snap_cap;
  assign wr_match  = bus_wr && rg == RG_MATCH;
  assign wr_count  = bus_wr && rg == RG_COUNT;
  assign wr_ctrl   = bus_wr && rg == RG_CTRL;
  assign wr_status = bus_wr && rg == RG_MISC && ix == 3'd0;
  assign wr_enable = bus_wr && rg == RG_MISC && ix == 3'd1;

  logic [CW-1:0]  cnt    [NCH];
  logic [CW-1:0]  nxt    [NCH];
  logic [CW-1:0]  mreg   [NCH];
  logic [9:0]     ctrl   [NCH];
  logic [2:0]     src_of [NCH];
  logic [NCH-1:0] adv, hit, clr;
  logic [NCH-1:0] st_q, en_q;
  logic [CW-1:0]  snap_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int         HEAD  = head_of(i);
    localparam logic [9:0] CMASK = (i < 4) ? 10'h0FF : 10'h3FF;
    logic       own, tick_i;
    logic [2:0] sel;

    assign own    = (HEAD == i) || ctrl[i][B_OWN];
    assign sel    = (i >= 4 && ctrl[i][B_F0]) ? 3'd0 : ctrl[i][2:0];
    assign tick_i = own && SRC_AVAIL[sel] && tick_src[sel];
    assign src_of[i] = ctrl[i][B_OWN] ? 3'(i) : 3'(HEAD);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl[i] <= '0;
        mreg[i] <= '0;
      end else begin
        if (wr_ctrl && ix == 3'(i))  ctrl[i] <= bus_wdata[9:0] & CMASK;
        if (wr_match && ix == 3'(i)) mreg[i] <= bus_wdata[CW-1:0];
      end
    end

    xmt_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_i),
      .load(wr_count && ix == 3'(i)), .load_val(bus_wdata[CW-1:0]),
      .clr(clr[i]), .cnt(cnt[i]), .nxt(nxt[i]), .adv(adv[i])
    );

    xmt_match #(.CW(CW)) u_match (
      .clk(clk), .rst_n(rst_n),
      .adv(adv[src_of[i]]), .nxt(nxt[src_of[i]]), .cmp(mreg[i]),
      .periodic(ctrl[i][B_PER]),
      .rearm((wr_match || wr_ctrl) && ix == 3'(i)),
      .hit(hit[i])
    );
  end

  always_comb begin
    clr = '0;
    for (int i = 0; i < NCH; i++)
      if (hit[i] && ctrl[i][B_RST]) clr[src_of[i]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= (st_q & ~(wr_status ? bus_wdata[ST_LO+NCH-1:ST_LO] : '0)) | (hit & en_q);
      if (wr_enable) en_q <= bus_wdata[ST_LO+NCH-1:ST_LO];
    end
  end

  assign irq = |st_q;

  assign snap_cap = bus_rd && rg == RG_COUNT && (ix == 3'd5 || ix == 3'd7) && ctrl[ix][B_SNAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (snap_cap) snap_q <= cnt[ix - 3'd1];
  end

  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    unique case (rg)
      RG_MATCH: rmux = 32'(mreg[ix]);
      RG_COUNT: rmux = 32'(cnt[ix]);
      RG_CTRL:  rmux = 32'(ctrl[ix]);
      RG_MISC: begin
        if (ix == 3'd0)      rmux = 32'(st_q) << ST_LO;
        else if (ix == 3'd1) rmux = 32'(en_q) << ST_LO;
        else if (ix == 3'd2) rmux = 32'(snap_q);
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rmux : '0;
  end

  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_status));
  assert_status_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (st_q & ~$past(st_q) & ~$past(en_q)) == '0);
  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cap |=> $stable(snap_q));
endmodule

// File: tb/tb_ext_match_timer.sv
module tb_ext_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tick_src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  localparam logic [7:0] AVAIL = 8'h3F;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ext_match_timer #(.CW(32), .SRC_AVAIL(AVAIL)) dut (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ticks(input logic [7:0] m, input int n);
    @(negedge clk); tick_src = m;
    repeat (n) @(negedge clk);
    tick_src = '0;
  endtask

  function automatic logic [4:0] A(input int rgn, input int idx);
    return 5'((rgn << 3) | idx);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(A(0,0), d); check("R11 match", d, 0);
    rd(A(1,3), d); check("R11 count", d, 0);
    rd(A(2,7), d); check("R11 ctrl", d, 0);
    rd(A(3,0), d); check("R11 status", d, 0);
    rd(A(3,1), d); check("R11 enable", d, 0);
    rd(A(3,2), d); check("R11 snapshot", d, 0);
    check("R11 irq", {31'd0, irq}, 0);

    // R3 stored control width
    for (int k = 0; k < 8; k++) begin
      wr(A(2,k), 32'hFFFF_FFFF);
      rd(A(2,k), d); check("R3 ctrl width", d, (k < 4) ? 32'h0FF : 32'h3FF);
      wr(A(2,k), 0);
    end

    // R1 source select sweep, own counter
    for (int k = 0; k < 8; k++)
      for (int s = 0; s < 8; s++) begin
        wr(A(2,k), 32'h80 | s);
        wr(A(1,k), 0);
        ticks(~(8'd1 << s), 3);
        ticks(8'd1 << s, 5);
        rd(A(1,k), d); check("R1 source sweep", d, AVAIL[s] ? 5 : 0);
      end

    // R4 force source 0
    for (int k = 4; k < 8; k++) begin
      wr(A(2,k), 32'h183);
      wr(A(1,k), 0);
      ticks(8'h08, 4);
      rd(A(1,k), d); check("R4 select ignored", d, 0);
      ticks(8'h01, 4);
      rd(A(1,k), d); check("R4 forced source0", d, 4);
    end

    // R2 counter sharing and R5/R9 status and irq
    for (int k = 0; k < 8; k++) begin
      wr(A(2,k), (k == 1) ? 32'h81 : 32'h0);
      wr(A(1,k), 0);
      wr(A(0,k), 3);
    end
    wr(A(3,1), 32'hFF0);
    ticks(8'h01, 3);
    rd(A(3,0), d); check("R2 shared matches", d, 32'hFD0);
    check("R9 irq high", {31'd0, irq}, 1);
    rd(A(1,0), d); check("R2 head ch4", d, 3);
    rd(A(1,1), d); check("R2 own ch5 idle", d, 0);
    rd(A(1,2), d); check("R2 member frozen", d, 0);
    rd(A(1,4), d); check("R2 head ch8", d, 3);
    rd(A(1,5), d); check("R2 member ch9", d, 0);
    wr(A(3,0), 32'h0F0);
    rd(A(3,0), d); check("R9 partial clear", d, 32'hF00);
    check("R9 irq still high", {31'd0, irq}, 1);
    wr(A(3,0), 32'hF00);
    rd(A(3,0), d); check("R9 all clear", d, 0);
    check("R9 irq low", {31'd0, irq}, 0);

    // R5 disabled channel records nothing
    wr(A(3,1), 0);
    wr(A(0,0), 6);
    ticks(8'h01, 3);
    rd(A(1,0), d); check("R5 counter reached", d, 6);
    rd(A(3,0), d); check("R5 disabled no status", d, 0);

    // R6 reset on match
    wr(A(2,3), 32'hCA);
    wr(A(1,3), 0);
    wr(A(0,3), 4);
    wr(A(3,1), 32'h080);
    ticks(8'h04, 10);
    rd(A(1,3), d); check("R6 wrap count", d, 2);
    rd(A(3,0), d); check("R6 status", d, 32'h080);
    wr(A(3,0), 32'hFF0);

    // R7 one-shot and periodic
    wr(A(2,2), 32'h82); wr(A(0,2), 2); wr(A(3,1), 32'h040);
    wr(A(1,2), 0); ticks(8'h04, 2);
    rd(A(3,0), d); check("R7 first match", d, 32'h040);
    wr(A(3,0), 32'hFF0);
    wr(A(1,2), 0); ticks(8'h04, 2);
    rd(A(3,0), d); check("R7 one-shot silent", d, 0);
    wr(A(2,2), 32'h82);
    wr(A(1,2), 0); ticks(8'h04, 2);
    rd(A(3,0), d); check("R7 rearmed", d, 32'h040);
    wr(A(3,0), 32'hFF0);
    wr(A(2,2), 32'hC2);
    wr(A(1,2), 0); ticks(8'h04, 2);
    wr(A(3,0), 32'hFF0);
    wr(A(1,2), 0); ticks(8'h04, 2);
    rd(A(3,0), d); check("R7 periodic again", d, 32'h040);
    wr(A(3,0), 32'hFF0);
    wr(A(3,1), 0);

    // R8 snapshot
    wr(A(2,4), 7); wr(A(1,4), 32'h1234);
    wr(A(2,5), 32'h200);
    rd(A(1,5), d);
    rd(A(3,2), d); check("R8 capture ch8", d, 32'h1234);
    wr(A(1,4), 32'h55); wr(A(2,5), 0);
    rd(A(1,5), d);
    rd(A(3,2), d); check("R8 hold without bit9", d, 32'h1234);
    wr(A(2,6), 7); wr(A(1,6), 32'h77); wr(A(2,7), 32'h200);
    rd(A(1,7), d);
    rd(A(3,2), d); check("R8 capture ch10", d, 32'h77);

    // R10 load beats tick
    wr(A(2,0), 0); wr(A(0,0), 32'hFFFF);
    @(negedge clk); tick_src = 8'hFF; bus_wr = 1'b1; bus_addr = A(1,0); bus_wdata = 32'hABCD;
    @(negedge clk); bus_wr = 1'b0; tick_src = 0;
    rd(A(1,0), d); check("R10 load priority", d, 32'hABCD);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule